// File: doc/BRIEF.md
# VP8 Frame Stream Stitcher

The block turns the separately produced pieces of one VP8 compressed frame into a single byte stream. A start pulse hands it the header length, the payload length, a key-frame flag, the picture width and height, and the free space of the destination buffer. From the header length and the frame type it forms the frame tag. It then emits the tag, the header bytes and the payload bytes back to back on one valid/ready byte output, with a last marker on the final byte.

Header and payload bytes arrive on two valid/ready byte inputs. Each input is passed through to the output without buffering, so an input byte is taken only in the cycle the output accepts it. Before any byte is sent, the frame size is checked against the buffer space. A frame that does not fit, or whose header length cannot be encoded in the tag, is refused at once with an error. When a frame finishes, a done pulse reports the total size in bytes.

Top module: `vp8_frame_stitcher`

## Requirements
- R1: The frame tag is the 24-bit value with bits 23:5 equal to the header length, bit 4 set to 1, bits 3:1 clear, and bit 0 equal to 0 for a key frame and 1 otherwise. It is sent as three bytes, bits 7:0 first, then 15:8, then 23:16.
- R2: A key frame has a 10-byte prefix. The tag comes first, then 0x9D, 0x01 and 0x2A, then width low byte, width high byte, height low byte and height high byte. All 16 bits of width and height pass through unmodified.
- R3: A non-key frame has a 3-byte prefix, which is the tag alone.
- R4: The output carries the prefix, then every header byte in arrival order, then every payload byte in arrival order, with nothing between them. A header or payload section of length zero contributes no bytes.
- R5: If the buffer space is less than header length plus payload length plus prefix size, the frame is refused. No byte is emitted, busy stays low, and in the next cycle done and error are high together with a total of 0.
- R6: A header length of 2^19 or more is refused in the same way as R5.
- R7: On the done pulse of an accepted frame, the total output equals header length plus payload length plus prefix size.
- R8: A header or payload input is ready only in its own section and only while the output is ready, so each input byte is consumed exactly when its copy is accepted at the output. While the output is stalled, its byte and valid hold.
- R9: Busy rises in the cycle after an accepted start and falls once the last byte has been accepted. A start pulse while busy is ignored, including any parameter values presented with it.
- R10: Done pulses for one cycle, with error low, in the cycle after the last byte is accepted.
- R11: The last marker is high on the final byte of the frame and on no other byte. This includes frames that end inside the prefix or the header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame; parameters sampled on this cycle |
| hdr_len_i | input | LEN_W | Header length in bytes |
| pay_len_i | input | LEN_W | Payload length in bytes |
| key_i | input | 1 | Frame is a key frame |
| width_i | input | 16 | Picture width field |
| height_i | input | 16 | Picture height field |
| cap_i | input | SIZE_W | Free space in the destination buffer, bytes |
| hdr_data_i | input | 8 | Header byte |
| hdr_valid_i | input | 1 | Header byte valid |
| hdr_ready_o | output | 1 | Header byte taken |
| pay_data_i | input | 8 | Payload byte |
| pay_valid_i | input | 1 | Payload byte valid |
| pay_ready_o | output | 1 | Payload byte taken |
| out_data_o | output | 8 | Output byte |
| out_valid_o | output | 1 | Output byte valid |
| out_last_o | output | 1 | Output byte is the final byte of the frame |
| out_ready_i | input | 1 | Sink accepts output byte |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Frame finished or refused, one-cycle pulse |
| err_o | output | 1 | Frame refused, valid with done |
| total_o | output | SIZE_W | Total frame size in bytes, valid with done |

## Verification
The hardest cases to reach are the section boundaries under backpressure. In these cases the output stalls exactly on the byte where the prefix hands over to the header, or the header hands over to the payload, while the input sources also insert gaps. A behavioural model in the bench builds the expected byte queue from the requirements. It throttles the output ready and both input valids in pseudo-random patterns, then compares every accepted byte and last marker against the queue.

Frames with an empty header, an empty payload, or both force the last marker into the header or the prefix. A frame whose size exactly equals the buffer space is run next to one that exceeds it by a single byte. A start pulse with different parameters is injected in the middle of a frame to show that it has no effect on the stream.

// File: rtl/vp8fs_pkg.sv
package vp8fs_pkg;
  localparam int TAG_LEN_W = 19;   // header length field inside the tag
  localparam int KEY_PRE   = 10;
  localparam int INTER_PRE = 3;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRE,
    PH_HDR,
    PH_PAY
  } phase_e;
endpackage

// File: rtl/vp8fs_sizer.sv
module vp8fs_sizer
  import vp8fs_pkg::*;
#(
  parameter int LEN_W  = 24,
  parameter int SIZE_W = LEN_W + 2
) (
  input  logic [LEN_W-1:0]  hdr_len_i,
  input  logic [LEN_W-1:0]  pay_len_i,
  input  logic              key_i,
  input  logic [SIZE_W-1:0] cap_i,
  output logic [3:0]        pre_len_o,
  output logic [SIZE_W-1:0] total_o,
  output logic              reject_o
);
  logic too_long;

  generate
    if (LEN_W > TAG_LEN_W) begin : g_len_chk
      assign too_long = |hdr_len_i[LEN_W-1:TAG_LEN_W];
    end else begin : g_len_ok
      assign too_long = 1'b0;
    end
  endgenerate

  assign pre_len_o = key_i ? 4'(KEY_PRE) : 4'(INTER_PRE);
  assign total_o   = SIZE_W'(hdr_len_i) + SIZE_W'(pay_len_i) + SIZE_W'(pre_len_o);
  assign reject_o  = too_long || (total_o > cap_i);
endmodule

// File: rtl/vp8fs_prefix.sv
module vp8fs_prefix
  import vp8fs_pkg::*;
(
  input  logic [3:0]           idx_i,
  input  logic [TAG_LEN_W-1:0] hdr_len_i,
  input  logic                 key_i,
  input  logic [15:0]          width_i,
  input  logic [15:0]          height_i,
  output logic [7:0]           byte_o
);
  logic [23:0] tag;

  assign tag = {hdr_len_i, 1'b1, 3'b000, ~key_i};

  always_comb begin
    unique case (idx_i)
      4'd0:    byte_o = tag[7:0];
      4'd1:    byte_o = tag[15:8];
      4'd2:    byte_o = tag[23:16];
      4'd3:    byte_o = 8'h9d;
      4'd4:    byte_o = 8'h01;
      4'd5:    byte_o = 8'h2a;
      4'd6:    byte_o = width_i[7:0];
      4'd7:    byte_o = width_i[15:8];
      4'd8:    byte_o = height_i[7:0];
      4'd9:    byte_o = height_i[15:8];
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/vp8_frame_stitcher.sv
module vp8_frame_stitcher
  import vp8fs_pkg::*;
#(
  parameter int LEN_W  = 24,
  parameter int SIZE_W = LEN_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  hdr_len_i,
  input  logic [LEN_W-1:0]  pay_len_i,
  input  logic              key_i,
  input  logic [15:0]       width_i,
  input  logic [15:0]       height_i,
  input  logic [SIZE_W-1:0] cap_i,
  input  logic [7:0]        hdr_data_i,
  input  logic              hdr_valid_i,
  output logic              hdr_ready_o,
  input  logic [7:0]        pay_data_i,
  input  logic              pay_valid_i,
  output logic              pay_ready_o,
  output logic [7:0]        out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  input  logic              out_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [SIZE_W-1:0] total_o
);
  phase_e             phase_q;
  logic [3:0]         idx_q, pre_len_q, pre_len_d;
  logic [LEN_W-1:0]   cnt_q, hdr_len_q, pay_len_q;
  logic               key_q, done_q, err_q;
  logic [15:0]        width_q, height_q;
  logic [SIZE_W-1:0]  total_q, total_d;
  logic               reject;
  logic [7:0]         pre_byte;
  logic               pre_end, hdr_end, pay_end, hdr_none, pay_none, xfer;

  vp8fs_sizer #(.LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_sizer (
    .hdr_len_i (hdr_len_i),
    .pay_len_i (pay_len_i),
    .key_i     (key_i),
    .cap_i     (cap_i),
    .pre_len_o (pre_len_d),
    .total_o   (total_d),
    .reject_o  (reject)
  );

  vp8fs_prefix u_prefix (
    .idx_i     (idx_q),
    .hdr_len_i (hdr_len_q[TAG_LEN_W-1:0]),
    .key_i     (key_q),
    .width_i   (width_q),
    .height_i  (height_q),
    .byte_o    (pre_byte)
  );

  assign hdr_none = (hdr_len_q == '0);
  assign pay_none = (pay_len_q == '0);
  assign pre_end  = (idx_q == pre_len_q - 4'd1);
  assign hdr_end  = (cnt_q == hdr_len_q - LEN_W'(1));
  assign pay_end  = (cnt_q == pay_len_q - LEN_W'(1));

  always_comb begin
    out_data_o  = 8'h00;
    out_valid_o = 1'b0;
    out_last_o  = 1'b0;
    hdr_ready_o = 1'b0;
    pay_ready_o = 1'b0;
    unique case (phase_q)
      PH_PRE: begin
        out_data_o  = pre_byte;
        out_valid_o = 1'b1;
        out_last_o  = pre_end && hdr_none && pay_none;
      end
      PH_HDR: begin
        out_data_o  = hdr_data_i;
        out_valid_o = hdr_valid_i;
        out_last_o  = hdr_end && pay_none;
        hdr_ready_o = out_ready_i;
      end
      PH_PAY: begin
        out_data_o  = pay_data_i;
        out_valid_o = pay_valid_i;
        out_last_o  = pay_end;
        pay_ready_o = out_ready_i;
      end
      default: ;
    endcase
  end

  assign xfer = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      idx_q     <= '0;
      cnt_q     <= '0;
      pre_len_q <= 4'(INTER_PRE);
      hdr_len_q <= '0;
      pay_len_q <= '0;
      key_q     <= 1'b0;
      width_q   <= '0;
      height_q  <= '0;
      total_q   <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          if (reject) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            total_q <= '0;
          end else begin
            phase_q   <= PH_PRE;
            idx_q     <= '0;
            cnt_q     <= '0;
            pre_len_q <= pre_len_d;
            hdr_len_q <= hdr_len_i;
            pay_len_q <= pay_len_i;
            key_q     <= key_i;
            width_q   <= width_i;
            height_q  <= height_i;
            total_q   <= total_d;
          end
        end
        PH_PRE: if (xfer) begin
          if (out_last_o) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else if (pre_end) begin
            phase_q <= hdr_none ? PH_PAY : PH_HDR;
            cnt_q   <= '0;
          end else begin
            idx_q <= idx_q + 4'd1;
          end
        end
        PH_HDR: if (xfer) begin
          if (out_last_o) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else if (hdr_end) begin
            phase_q <= PH_PAY;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + LEN_W'(1);
          end
        end
        PH_PAY: if (xfer) begin
          if (out_last_o) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + LEN_W'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign total_o = total_q;
endmodule

// File: rtl/vp8fs_checker.sv
module vp8fs_checker #(
  parameter int LEN_W  = 24,
  parameter int SIZE_W = LEN_W + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hdr_ready_o,
  input logic              pay_ready_o,
  input logic [7:0]        out_data_o,
  input logic              out_valid_o,
  input logic              out_last_o,
  input logic              out_ready_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [SIZE_W-1:0] total_o
);
  assert_single_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdr_ready_o && pay_ready_o));

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !out_valid_o && !hdr_ready_o && !pay_ready_o);

  assert_last_then_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> done_o && !err_o && !busy_o);

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_needs_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && !busy_o && total_o == '0);
endmodule

bind vp8_frame_stitcher vp8fs_checker #(.LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_vp8fs_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hdr_ready_o (hdr_ready_o),
  .pay_ready_o (pay_ready_o),
  .out_data_o  (out_data_o),
  .out_valid_o (out_valid_o),
  .out_last_o  (out_last_o),
  .out_ready_i (out_ready_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .total_o     (total_o)
);

// File: tb/vp8_frame_stitcher_bench.sv
module vp8_frame_stitcher_bench;
  localparam int LEN_W  = 24;
  localparam int SIZE_W = LEN_W + 2;

  logic clk_i = 1'b0;
  always #2 clk_i = ~clk_i;

  logic              rst_ni, start_i, key_i;
  logic [LEN_W-1:0]  hdr_len_i, pay_len_i;
  logic [15:0]       width_i, height_i;
  logic [SIZE_W-1:0] cap_i;
  logic [7:0]        hdr_data_i, pay_data_i, out_data_o;
  logic              hdr_valid_i, hdr_ready_o, pay_valid_i, pay_ready_o;
  logic              out_valid_o, out_last_o, out_ready_i;
  logic              busy_o, done_o, err_o;
  logic [SIZE_W-1:0] total_o;

  vp8_frame_stitcher #(.LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_vp8_frame_stitcher (.*);

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] exp_q[$];
  logic [7:0] hdr_q[$];
  logic [7:0] pay_q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic run_frame(input int hl, input int pl, input bit key, input logic [15:0] w,
                           input logic [15:0] h, input longint cap, input int mode, input bit poke);
    int pre;
    longint tot;
    bit rej, fin, hv, pv, hpop, ppop;
    logic [23:0] tag;
    int guard;
    pre = key ? 10 : 3;
    tot = longint'(hl) + longint'(pl) + longint'(pre);
    rej = (hl >= (1 << 19)) || (tot > cap);
    exp_q.delete(); hdr_q.delete(); pay_q.delete();
    if (!rej) begin
      tag = {hl[18:0], 1'b1, 3'b000, ~key};  // R1
      exp_q.push_back(tag[7:0]); exp_q.push_back(tag[15:8]); exp_q.push_back(tag[23:16]);
      if (key) begin  // R2
        exp_q.push_back(8'h9d); exp_q.push_back(8'h01); exp_q.push_back(8'h2a);
        exp_q.push_back(w[7:0]); exp_q.push_back(w[15:8]);
        exp_q.push_back(h[7:0]); exp_q.push_back(h[15:8]);
      end
      for (int i = 0; i < hl; i++) begin
        hdr_q.push_back(8'(8'ha0 + i * 3)); exp_q.push_back(8'(8'ha0 + i * 3));
      end
      for (int i = 0; i < pl; i++) begin
        pay_q.push_back(8'(8'h05 + i * 7)); exp_q.push_back(8'(8'h05 + i * 7));
      end
    end
    @(negedge clk_i);
    start_i = 1'b1; hdr_len_i = LEN_W'(hl); pay_len_i = LEN_W'(pl); key_i = key;
    width_i = w; height_i = h; cap_i = SIZE_W'(cap);
    out_ready_i = 1'b0; hdr_valid_i = 1'b0; pay_valid_i = 1'b0;
    #1 chk(!busy_o, "R9 idle before start", busy_o, 0);
    @(negedge clk_i);
    start_i = 1'b0;
    #1;
    if (rej) begin
      chk(done_o && err_o, "R5/R6 refused frame flags done+err", {done_o, err_o}, 3);
      chk(!busy_o && !out_valid_o, "R5 refused frame emits nothing", {busy_o, out_valid_o}, 0);
      chk(total_o == 0, "R5 refused frame total", total_o, 0);
      return;
    end
    chk(busy_o && !done_o, "R9 busy after start", {busy_o, done_o}, 2);
    hv = 0; pv = 0; hpop = 0; ppop = 0; fin = 0; guard = 0;
    forever begin
      @(negedge clk_i);
      if (hpop) void'(hdr_q.pop_front());
      if (ppop) void'(pay_q.pop_front());
      if (fin) begin
        out_ready_i = 1'b0; hdr_valid_i = 1'b0; pay_valid_i = 1'b0;
        #1;
        chk(done_o && !err_o, "R10 done pulse after last", {done_o, err_o}, 2);
        chk(total_o == SIZE_W'(tot), "R7 total size", total_o, tot);
        chk(!busy_o, "R9 busy falls after last", busy_o, 0);
        break;
      end
      start_i = poke && (guard == 4);  // R9: ignored while busy
      if (start_i) begin
        hdr_len_i = 1; pay_len_i = 2; key_i = ~key; width_i = ~w; cap_i = 0;
      end
      out_ready_i = (mode == 0) ? 1'b1 : 1'(($urandom % 2) != 0);
      hv = (hv && !hpop) ? 1'b1 : (hdr_q.size() > 0) && (mode == 0 || ($urandom % 3) != 0);
      pv = (pv && !ppop) ? 1'b1 : (pay_q.size() > 0) && (mode == 0 || ($urandom % 3) != 0);
      hdr_valid_i = hv; hdr_data_i = (hdr_q.size() > 0) ? hdr_q[0] : 8'h00;
      pay_valid_i = pv; pay_data_i = (pay_q.size() > 0) ? pay_q[0] : 8'h00;
      #1;
      hpop = hdr_valid_i && hdr_ready_o;
      ppop = pay_valid_i && pay_ready_o;
      chk(!((hpop || ppop) && !(out_valid_o && out_ready_i)),
          "R8 input taken without output transfer", {hpop, ppop}, 0);
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) chk(0, "R4 extra output byte", out_data_o, 0);
        else begin
          chk(out_data_o == exp_q[0], "R1/R2/R3/R4 byte order and value", out_data_o, exp_q[0]);
          chk(out_last_o == (exp_q.size() == 1), "R11 last marker", out_last_o, exp_q.size() == 1);
          fin = (exp_q.size() == 1);
          void'(exp_q.pop_front());
        end
      end
      if (!fin) chk(busy_o && !done_o, "R9 busy during frame", {busy_o, done_o}, 2);
      guard++;
      if (guard > 20000) begin
        chk(0, "R4 frame never completed", exp_q.size(), 0);
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; key_i = 1'b0; hdr_len_i = '0; pay_len_i = '0;
    width_i = '0; height_i = '0; cap_i = '0; hdr_data_i = '0; pay_data_i = '0;
    hdr_valid_i = 1'b0; pay_valid_i = 1'b0; out_ready_i = 1'b0;
    repeat (3) @(negedge clk_i);
    #1;
    chk(!busy_o && !done_o && !err_o && total_o == 0, "R9 reset state",
        {busy_o, done_o, err_o}, 0);
    chk(!out_valid_o && !hdr_ready_o && !pay_ready_o, "R8 reset handshakes",
        {out_valid_o, hdr_ready_o, pay_ready_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R2 key frame with scaling bits in width/height
    run_frame(5, 7, 1'b1, 16'hc280, 16'h41e0, 1000, 0, 0);
    // R3 non-key frame, backpressure, start poked while busy (R9)
    run_frame(3, 4, 1'b0, 16'h0140, 16'h00f0, 1000, 1, 1);
    // R11 frame ending inside the prefix
    run_frame(0, 0, 1'b1, 16'h1234, 16'h5678, 1000, 1, 0);
    run_frame(0, 0, 1'b0, 16'h0000, 16'h0000, 3, 0, 0);
    // R4 empty header / empty payload
    run_frame(0, 5, 1'b0, 16'h0010, 16'h0010, 1000, 1, 0);
    run_frame(6, 0, 1'b1, 16'h0020, 16'h0030, 1000, 1, 0);
    // R5 capacity boundary: exact fit accepted, one short refused
    run_frame(4, 4, 1'b1, 16'h0001, 16'h0002, 18, 1, 0);
    run_frame(4, 4, 1'b1, 16'h0001, 16'h0002, 17, 1, 0);
    run_frame(4, 4, 1'b0, 16'h0001, 16'h0002, 10, 0, 0);
    // R6 header length beyond the tag field
    run_frame(1 << 19, 0, 1'b0, 16'h0001, 16'h0001, 64'd33554431, 0, 0);
    // R1 upper tag bits with a long header, R8 under heavy stalls
    run_frame(837, 21, 1'b0, 16'h0500, 16'h02d0, 5000, 1, 1);
    run_frame(300, 300, 1'b1, 16'hffff, 16'h8001, 1000, 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule